// File: doc/BRIEF.md
# Snooze Entry and Recovery Sequencer

This block controls how a synchronous memory moves into a low-power snooze state and back out of it. The memory keeps its data while snoozing. A sleep request arrives on a pin that has no timing relation to the clock. The block first passes it through a synchronizer, then counts a fixed entry window in clock cycles. When the window ends, it gates every other memory input and forces the data bus drivers to high impedance.

When the request is withdrawn, the low-power status flag clears at once. The input gate and the bus disable stay on through a fixed recovery window. During that window, the memory controller may only issue deselect or read cycles. Any other cycle type seen in the window sets a violation flag. The flag holds until reset. An operation in flight when snooze begins is not guaranteed to complete. The block does not try to protect it, and array retention is modelled simply by leaving the array untouched.

Top module: `snz_sequencer`

## Requirements
- R1: While the synchronous active-high reset is sampled high, `in_gate`, `out_hiz`, `lowpwr` and `viol` are all 0 after the edge.
- R2: With the defaults (two synchronizer stages, two entry cycles), a sleep request that rises between two edges leaves the outputs unchanged for the next four rising edges.
- R3: On the fifth rising edge after the sleep request rises, `in_gate`, `out_hiz` and `lowpwr` all become 1 and stay 1 while the request is held.
- R4: When the sleep request falls, `lowpwr` drops on the second rising edge after the fall, with no exit delay. `in_gate` and `out_hiz` remain 1 at that point.
- R5: `in_gate` and `out_hiz` return to 0 on the fifth rising edge after the sleep request falls, which closes a two-cycle recovery window.
- R6: `cyc_type` encodes 0 = deselect, 1 = read, 2 = write, 3 = burst continue. A code of 2 or 3 sampled during the recovery window sets `viol` on that same edge.
- R7: Once set, `viol` stays 1 until reset is applied, and reset clears it.
- R8: Outside the recovery window, `cyc_type` has no effect on `viol`. This holds both in normal operation and while snoozed.
- R9: A sleep request that falls again before the entry window completes never asserts `in_gate`, `out_hiz` or `lowpwr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sleep_async | input | 1 | Sleep request, asynchronous, active high |
| cyc_type | input | 2 | Decoded cycle type from the controller |
| in_gate | output | 1 | Blocks all other memory inputs when 1 |
| out_hiz | output | 1 | Forces the data bus to high impedance when 1 |
| lowpwr | output | 1 | Low-power status flag |
| viol | output | 1 | Sticky flag for a disallowed cycle during recovery |

## Verification
A phase register stuck in, or skipping, the entry or recovery state appears as `in_gate` rising or falling one or more edges away from the fifth edge after a sleep transition. That is visible within six cycles of the transition. A mis-sized counter shifts those same edges. A wrong synchronizer depth moves both entry and exit together, and also shifts the edge on which `lowpwr` drops. A fault in the violation window shows up as `viol` rising for a write issued while snoozed, or staying low for a write on the last recovery edge. The bench probes both edges of that window.

// File: rtl/snz_pkg.sv
package snz_pkg;

    typedef enum logic [1:0] {
        CYC_DESEL = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2,
        CYC_CONT  = 2'd3
    } cyc_e;

    typedef enum logic [1:0] {
        PH_ACTIVE  = 2'd0,
        PH_ENTER   = 2'd1,
        PH_SNOOZE  = 2'd2,
        PH_RECOVER = 2'd3
    } phase_e;

    typedef struct packed {
        logic gate;
        logic hiz;
        logic low;
    } ctl_t;

    function automatic logic recovery_ok(input cyc_e c);
        return (c == CYC_DESEL) || (c == CYC_READ);
    endfunction

    function automatic logic phase_gated(input phase_e p);
        return (p == PH_SNOOZE) || (p == PH_RECOVER);
    endfunction

endpackage

// File: rtl/snz_sync.sv
module snz_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/snz_phase_fsm.sv
module snz_phase_fsm
    import snz_pkg::*;
#(
    parameter int ENTRY_CYC = 2,
    parameter int RECOV_CYC = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   sleep_s,
    output phase_e phase
);
    localparam int MAXC = (ENTRY_CYC > RECOV_CYC) ? ENTRY_CYC : RECOV_CYC;
    localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;
    localparam logic [CW-1:0] ENTRY_LAST = CW'(ENTRY_CYC - 1);
    localparam logic [CW-1:0] RECOV_LAST = CW'(RECOV_CYC - 1);

    phase_e        st;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= PH_ACTIVE;
            cnt <= '0;
        end else begin
            case (st)
                PH_ACTIVE: begin
                    if (sleep_s) begin
                        st  <= PH_ENTER;
                        cnt <= '0;
                    end
                end
                PH_ENTER: begin
                    if (!sleep_s) begin
                        st  <= PH_ACTIVE;
                        cnt <= '0;
                    end else if (cnt == ENTRY_LAST) begin
                        st  <= PH_SNOOZE;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_SNOOZE: begin
                    if (!sleep_s) begin
                        st  <= PH_RECOVER;
                        cnt <= '0;
                    end
                end
                default: begin
                    if (sleep_s) begin
                        st  <= PH_ENTER;
                        cnt <= '0;
                    end else if (cnt == RECOV_LAST) begin
                        st  <= PH_ACTIVE;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    assign phase = st;

    // R3: snooze is only ever reached through the entry window
    p_snooze_from_entry_r3: assert property (@(posedge clk) disable iff (rst)
        (st == PH_SNOOZE && $past(st) != PH_SNOOZE) |-> $past(st) == PH_ENTER);

    // R5: a release from snooze always passes through recovery
    p_snooze_exit_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(st) == PH_SNOOZE && st != PH_SNOOZE) |-> st == PH_RECOVER);

    // R9: dropping the request during entry returns to normal operation
    p_abort_entry_r9: assert property (@(posedge clk) disable iff (rst)
        (st == PH_ENTER && !sleep_s) |=> st == PH_ACTIVE);
endmodule

// File: rtl/snz_viol_mon.sv
module snz_viol_mon
    import snz_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_e phase,
    input  cyc_e   cyc,
    output logic   viol
);
    logic flag;

    always_ff @(posedge clk) begin
        if (rst)                                         flag <= 1'b0;
        else if (phase == PH_RECOVER && !recovery_ok(cyc)) flag <= 1'b1;
    end

    assign viol = flag;

    // R7: the flag never clears without reset
    p_viol_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        flag |=> flag);

    // R8: the flag can only rise from a recovery-window sample
    p_viol_source_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(phase) == PH_RECOVER);

    // R6: a forbidden cycle in recovery is flagged on the next state
    p_viol_catch_r6: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RECOVER && (cyc == CYC_WRITE || cyc == CYC_CONT)) |=> flag);
endmodule

// File: rtl/snz_sequencer.sv
module snz_sequencer
    import snz_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ENTRY_CYC   = 2,
    parameter int RECOV_CYC   = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sleep_async,
    input  logic [1:0] cyc_type,
    output logic       in_gate,
    output logic       out_hiz,
    output logic       lowpwr,
    output logic       viol
);
    logic   sleep_s;
    phase_e phase;
    ctl_t   ctl;

    snz_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (sleep_async),
        .q_sync  (sleep_s)
    );

    snz_phase_fsm #(.ENTRY_CYC(ENTRY_CYC), .RECOV_CYC(RECOV_CYC)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .sleep_s (sleep_s),
        .phase   (phase)
    );

    snz_viol_mon u_mon (
        .clk   (clk),
        .rst   (rst),
        .phase (phase),
        .cyc   (cyc_e'(cyc_type)),
        .viol  (viol)
    );

    always_comb begin
        ctl.gate = phase_gated(phase);
        ctl.hiz  = phase_gated(phase);
        ctl.low  = (phase == PH_SNOOZE) && sleep_s;
    end

    assign in_gate = ctl.gate;
    assign out_hiz = ctl.hiz;
    assign lowpwr  = ctl.low;

    // R3: low power implies both gates closed
    p_low_gated_r3: assert property (@(posedge clk) disable iff (rst)
        lowpwr |-> (in_gate && out_hiz));

    // R4: low power never outlives the synchronized request
    p_low_follows_req_r4: assert property (@(posedge clk) disable iff (rst)
        !sleep_s |-> !lowpwr);
endmodule

// File: tb/snz_sequencer_bench.sv
module snz_sequencer_bench;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sleep_async = 1'b0;
    logic [1:0] cyc_type = 2'd0;
    logic       in_gate, out_hiz, lowpwr, viol;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [3:0] q_exp[$];
    string      q_tag[$];

    always #(PERIOD/2) clk = ~clk;

    snz_sequencer u_snz_sequencer (
        .clk         (clk),
        .rst         (rst),
        .sleep_async (sleep_async),
        .cyc_type    (cyc_type),
        .in_gate     (in_gate),
        .out_hiz     (out_hiz),
        .lowpwr      (lowpwr),
        .viol        (viol)
    );

    // driver: one cycle of stimulus, expectation {gate,hiz,low,viol} after next edge
    task automatic step(input logic rs, input logic sl, input logic [1:0] ct,
                        input logic [3:0] exp, input string tag);
        @(negedge clk);
        rst         = rs;
        sleep_async = sl;
        cyc_type    = ct;
        q_exp.push_back(exp);
        q_tag.push_back(tag);
    endtask

    // monitor: compares a quarter period after each rising edge
    always @(posedge clk) begin
        #(PERIOD/4);
        if (q_exp.size() > 0) begin
            logic [3:0] e;
            string      t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            total++;
            if ({in_gate, out_hiz, lowpwr, viol} !== e) begin
                bad++;
                $display("FAIL %s: got gate/hiz/low/viol=%b expected %b",
                         t, {in_gate, out_hiz, lowpwr, viol}, e);
            end
        end
    end

    task automatic enter_snooze();
        for (int i = 0; i < 4; i++) step(0, 1, 2'd0, 4'b0000, "R2");
        step(0, 1, 2'd0, 4'b1110, "R3");
    endtask

    initial begin
        for (int i = 0; i < 3; i++) step(1, 0, 2'd0, 4'b0000, "R1");
        step(0, 0, 2'd2, 4'b0000, "R8");
        step(0, 0, 2'd3, 4'b0000, "R8");

        // first snooze, clean recovery
        enter_snooze();
        step(0, 1, 2'd2, 4'b1110, "R8");
        step(0, 1, 2'd3, 4'b1110, "R8");
        step(0, 1, 2'd2, 4'b1110, "R3");
        step(0, 0, 2'd0, 4'b1110, "R4");
        step(0, 0, 2'd0, 4'b1100, "R4");
        step(0, 0, 2'd1, 4'b1100, "R5");
        step(0, 0, 2'd1, 4'b1100, "R5");
        step(0, 0, 2'd0, 4'b0000, "R5");
        step(0, 0, 2'd2, 4'b0000, "R8");

        // aborted entry
        step(0, 1, 2'd0, 4'b0000, "R9");
        for (int i = 0; i < 5; i++) step(0, 0, 2'd0, 4'b0000, "R9");

        // second snooze, write on first recovery edge
        enter_snooze();
        step(0, 0, 2'd0, 4'b1110, "R4");
        step(0, 0, 2'd0, 4'b1100, "R4");
        step(0, 0, 2'd0, 4'b1100, "R5");
        step(0, 0, 2'd2, 4'b1101, "R6");
        step(0, 0, 2'd0, 4'b0001, "R5");
        step(0, 0, 2'd1, 4'b0001, "R7");
        step(0, 0, 2'd0, 4'b0001, "R7");
        step(1, 0, 2'd0, 4'b0000, "R7");
        step(0, 0, 2'd0, 4'b0000, "R1");

        // third snooze, burst continue on last recovery edge
        enter_snooze();
        step(0, 0, 2'd0, 4'b1110, "R4");
        step(0, 0, 2'd0, 4'b1100, "R4");
        step(0, 0, 2'd0, 4'b1100, "R5");
        step(0, 0, 2'd1, 4'b1100, "R6");
        step(0, 0, 2'd3, 4'b0001, "R6");
        step(0, 0, 2'd0, 4'b0001, "R7");

        step(0, 0, 2'd0, 4'b0001, "R7");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(PERIOD * 5000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule